// File: doc/BRIEF.md
# Pulse-Width Ring Buzzer Driver

This block produces the one-bit buzzer output of a ringer. Its pulse-width period is one period of the first tone (f1). The block takes the upper bits of the f1 phase accumulator from the tone generator and compares them with a 6-bit duty code. The output is active for code/128 of every f1 period.

When the second tone (f2) is also enabled, the f2 square wave gates the pulse train. This gives a warbling, amplitude-modulated ring.

A polarity bit picks which logic level counts as active. The same bit sets the level the output rests at when the buzzer is off or powered down. The output is a register that loads only on sample ticks, so it is glitch-free and changes only on tick boundaries.

Top module: `buzz_ring_pwm`

## Requirements
- R1: While rstN is low, bz is 0.
- R2: bz changes only on the clock edge that follows a cycle with sampleTick high. In every other cycle it holds its value.
- R3: On a tick, the active condition is true when all of the following hold: buzzEn=1, powerDown=0, f1En=1, and f1PhaseTop (the upper 7 bits of the f1 accumulator, taken as unsigned) is less than duty. With invPol=0, bz then becomes 1; otherwise it becomes 0.
- R4: Over 128 consecutive ticks in which f1PhaseTop steps through all 128 values, with no f2 gating, bz is active in exactly duty of them.
- R5: With invPol=1 the sense is inverted: the active level is 0 and the idle level is 1.
- R6: On a tick with buzzEn=0 or powerDown=1, bz takes the idle level, which equals invPol.
- R7: On a tick with f1En=0, bz takes the idle level, whatever f2En is.
- R8: With f1En=1 and f2En=1, on a tick where f2Sq=0, bz takes the idle level. Where f2Sq=1, bz follows R3.
- R9: A duty code of 0 keeps bz at the idle level even when the buzzer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| buzzEn | input | 1 | Buzzer enable |
| powerDown | input | 1 | Power-down; forces the idle level |
| invPol | input | 1 | Polarity: 0 means the active level is 1, 1 means the active level is 0 |
| duty | input | DUTY_W (6) | Duty code; active width is duty/128 of the f1 period |
| f1En | input | 1 | First tone enable |
| f2En | input | 1 | Second tone enable (modulation) |
| sampleTick | input | 1 | Output update strobe |
| f1PhaseTop | input | DUTY_W+1 (7) | Upper bits of the f1 phase accumulator |
| f2Sq | input | 1 | f2 square wave (f2 phase MSB) |
| bz | output | 1 | Buzzer output |

## Verification
The bench sweeps f1PhaseTop through full periods at several duty codes, including 0, 1 and the maximum of 63. This separates a correct strict-less-than comparison from an off-by-one compare. Ticks are sent every cycle and also sparsely, which shows whether the output register loads only on ticks. The bench toggles f2Sq while both tones are enabled, which tells modulation apart from plain pulse output. Runs with invPol at both values, with enable, power-down and f1 each removed in turn, show whether the idle level follows polarity in every off state.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic load;     // register the new level this cycle
    logic run;      // pulse generation allowed
    logic gateF2;   // second tone gates the pulse train
    logic idleLvl;  // resting level (also polarity)
  } buzzCtl_t;
endpackage

// File: rtl/buzz_ctl.sv
module buzz_ctl #(
  parameter int DUTY_W = 6
) (
  input  logic                 buzzEn,
  input  logic                 powerDown,
  input  logic                 invPol,
  input  logic                 f1En,
  input  logic                 f2En,
  input  logic                 sampleTick,
  input  logic [DUTY_W-1:0]    duty,
  output buzz_pkg::buzzCtl_t   ctl
);
  logic dutyNonZero;

  always_comb begin
    dutyNonZero  = |duty;
    ctl.load     = sampleTick;
    ctl.run      = buzzEn & ~powerDown & f1En & dutyNonZero;
    ctl.gateF2   = f2En;
    ctl.idleLvl  = invPol;
  end
endmodule

// File: rtl/buzz_dp.sv
module buzz_dp #(
  parameter int DUTY_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  buzz_pkg::buzzCtl_t   ctl,
  input  logic [DUTY_W-1:0]    duty,
  input  logic [DUTY_W:0]      f1PhaseTop,
  input  logic                 f2Sq,
  output logic                 bz
);
  localparam int CMP_W = DUTY_W + 1;

  logic [CMP_W-1:0] dutyExt;
  logic             inWindow;
  logic             gateOpen;
  logic             nextLvl;

  always_comb begin
    dutyExt  = {1'b0, duty};
    inWindow = f1PhaseTop < dutyExt;
    gateOpen = ~ctl.gateF2 | f2Sq;
    nextLvl  = (ctl.run & inWindow & gateOpen) ^ ctl.idleLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         bz <= 1'b0;
    else if (ctl.load) bz <= nextLvl;
  end
endmodule

// File: rtl/buzz_ring_pwm.sv
module buzz_ring_pwm #(
  parameter int DUTY_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              buzzEn,
  input  logic              powerDown,
  input  logic              invPol,
  input  logic [DUTY_W-1:0] duty,
  input  logic              f1En,
  input  logic              f2En,
  input  logic              sampleTick,
  input  logic [DUTY_W:0]   f1PhaseTop,
  input  logic              f2Sq,
  output logic              bz
);
  buzz_pkg::buzzCtl_t ctl;

  buzz_ctl #(.DUTY_W(DUTY_W)) ctlI (
    .buzzEn(buzzEn), .powerDown(powerDown), .invPol(invPol),
    .f1En(f1En), .f2En(f2En), .sampleTick(sampleTick),
    .duty(duty), .ctl(ctl)
  );

  buzz_dp #(.DUTY_W(DUTY_W)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .duty(duty),
    .f1PhaseTop(f1PhaseTop), .f2Sq(f2Sq), .bz(bz)
  );
endmodule

// File: rtl/buzz_ring_pwm_chk.sv
module buzz_ring_pwm_chk #(
  parameter int DUTY_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              buzzEn,
  input logic              powerDown,
  input logic              invPol,
  input logic [DUTY_W-1:0] duty,
  input logic              f1En,
  input logic              f2En,
  input logic              sampleTick,
  input logic [DUTY_W:0]   f1PhaseTop,
  input logic              f2Sq,
  input logic              bz
);
  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && rstN) |=> $stable(bz));

  // R6
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && (!buzzEn || powerDown)) |=> (bz == $past(invPol)));

  // R7
  no_f1_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && !f1En) |=> (bz == $past(invPol)));

  // R8
  f2_gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && f2En && !f2Sq) |=> (bz == $past(invPol)));

  // R9
  zero_duty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && duty == '0) |=> (bz == $past(invPol)));

  // R3
  active_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && buzzEn && !powerDown && f1En && !f2En &&
     ({1'b0, duty} > f1PhaseTop)) |=> (bz != $past(invPol)));
endmodule

bind buzz_ring_pwm buzz_ring_pwm_chk #(.DUTY_W(DUTY_W)) chkI (
  .clk(clk), .rstN(rstN), .buzzEn(buzzEn), .powerDown(powerDown),
  .invPol(invPol), .duty(duty), .f1En(f1En), .f2En(f2En),
  .sampleTick(sampleTick), .f1PhaseTop(f1PhaseTop), .f2Sq(f2Sq), .bz(bz)
);

// File: tb/buzz_ring_pwm_test.sv
`timescale 1ns/1ps
module buzz_ring_pwm_test;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rstN, buzzEn, powerDown, invPol, f1En, f2En, sampleTick, f2Sq;
  logic [DW-1:0] duty;
  logic [DW:0]   f1PhaseTop;
  logic          bz;

  int nCmp = 0;
  int nBad = 0;
  string curTag = "R1";
  bit expBz = 1'b0;
  bit cmpOn = 1'b0;

  always #2.5 clk = ~clk;

  buzz_ring_pwm #(.DUTY_W(DW)) uut (
    .clk(clk), .rstN(rstN), .buzzEn(buzzEn), .powerDown(powerDown),
    .invPol(invPol), .duty(duty), .f1En(f1En), .f2En(f2En),
    .sampleTick(sampleTick), .f1PhaseTop(f1PhaseTop), .f2Sq(f2Sq), .bz(bz)
  );

  // behavioural reference: active fraction duty/128 of the f1 period
  always @(posedge clk) begin
    int ph, dc;
    bit on;
    ph = int'(f1PhaseTop);
    dc = int'(duty);
    on = buzzEn && !powerDown && f1En && (ph < dc) && (!f2En || f2Sq);
    if (!rstN) expBz <= 1'b0;
    else if (sampleTick) expBz <= on ? !invPol : invPol;
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      nCmp++;
      if (bz !== expBz) begin
        nBad++;
        $display("FAIL %s t=%0t bz actual=%b expected=%b", curTag, $time, bz, expBz);
      end
    end
  end

  task automatic runPat(string tag, int cycles, int tickEvery, int f2Half);
    curTag = tag;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      f1PhaseTop = f1PhaseTop + 1'b1;
      sampleTick = (i % tickEvery) == 0;
      if ((i % f2Half) == 0) f2Sq = ~f2Sq;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; buzzEn = 1'b1; powerDown = 1'b0; invPol = 1'b1;
    duty = 6'd20; f1En = 1'b1; f2En = 1'b0; sampleTick = 1'b1;
    f1PhaseTop = '0; f2Sq = 1'b0;
    // R1: output low during reset regardless of polarity
    curTag = "R1";
    cmpOn = 1'b1;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1; invPol = 1'b0;

    runPat("R3", 300, 1, 1000);
    duty = 6'd1;  runPat("R3", 256, 1, 1000);
    duty = 6'd63; runPat("R3", 256, 1, 1000);
    duty = 6'd40; runPat("R2", 400, 3, 1000);
    duty = 6'd25; runPat("R2", 400, 7, 1000);

    // R4: exact active count over one full sweep
    begin
      int hi = 0;
      @(posedge clk); #1;
      duty = 6'd37; f2En = 1'b0; sampleTick = 1'b1; f1PhaseTop = '0;
      for (int i = 0; i < 128; i++) begin
        @(posedge clk); #1;
        f1PhaseTop = f1PhaseTop + 1'b1;
        @(negedge clk);
        if (bz) hi++;
      end
      nCmp++;
      if (hi != 37) begin
        nBad++;
        $display("FAIL R4 active count actual=%0d expected=%0d", hi, 37);
      end
    end

    invPol = 1'b1; duty = 6'd50; runPat("R5", 300, 1, 1000);
    runPat("R5", 300, 2, 1000);
    buzzEn = 1'b0; runPat("R6", 200, 1, 1000);
    buzzEn = 1'b1; powerDown = 1'b1; runPat("R6", 200, 1, 1000);
    invPol = 1'b0; runPat("R6", 200, 1, 1000);
    powerDown = 1'b0; f1En = 1'b0; f2En = 1'b1; runPat("R7", 200, 1, 30);
    f1En = 1'b1; duty = 6'd60; runPat("R8", 800, 1, 37);
    invPol = 1'b1; runPat("R8", 800, 2, 50);
    f2En = 1'b0; duty = 6'd0; runPat("R9", 300, 1, 1000);
    invPol = 1'b0; runPat("R9", 300, 1, 1000);

    @(posedge clk); #1;
    summary();
  end
endmodule